// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block walks the element index of one vectorised instruction. A start strobe brings in three things together: the requested vector length and, for each operand, two flags. The first flag says whether the operand's register lookup found an active redirection. The second says whether that redirection is a vector. The block then emits one element-valid cycle per element. Each valid cycle carries the current element offset. Downstream logic adds that offset to vectorised register targets and uses it as the bit index into the predicate mask.

The loop runs only when at least one operand is redirected and the vector length is non-zero. In every other case the instruction is treated as scalar: exactly one element-valid cycle is issued, with offset 0. Vector lengths larger than XLEN are clamped to XLEN, because the predicate holds only XLEN bits. After the last element, a done pulse lasts one cycle and the block returns to idle. Any start strobe that arrives while the block is busy is ignored.

A per-operand step mask accompanies each valid cycle. Its bit k tells the remapping stage whether operand k takes the offset, which is the case when that operand is both redirected and vectorised.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, `elem_vld_o`, `done_o` and `op_step_o` are 0 and `elem_off_o` is 0.
- R2: A start sampled while idle, with vector length n (1 ≤ n ≤ XLEN) and at least one operand redirected, produces exactly n consecutive element-valid cycles. The first of these is the cycle right after the start edge, and their offsets are 0, 1, …, n−1 in order.
- R3: A start with vector length 0 produces exactly one element-valid cycle with offset 0.
- R4: A start with no operand redirected produces exactly one element-valid cycle with offset 0, whatever the vector length.
- R5: A vector length above XLEN behaves as XLEN: XLEN valid cycles with offsets 0 to XLEN−1.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last element-valid cycle. It is never high together with `elem_vld_o`, and the block is idle in the cycle after it.
- R7: `start_i` has no effect while `elem_vld_o` or `done_o` is high.
- R8: While `elem_vld_o` is high, bit k of `op_step_o` equals (redirected AND vectorised) for operand k as sampled at start. While `elem_vld_o` is low, `op_step_o` is 0.
- R9: Changes to `vlen_i`, `op_redir_i` or `op_vec_i` after the start edge have no effect on the element count, the offsets or `op_step_o` of the running loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new instruction loop (taken only when idle) |
| vlen_i | input | VL_W | Requested vector length |
| op_redir_i | input | NOPS | Per operand: lookup hit an active redirection |
| op_vec_i | input | NOPS | Per operand: redirection is a vector |
| elem_off_o | output | OFF_W | Current element offset (0 when not valid) |
| elem_vld_o | output | 1 | Element-valid strobe |
| op_step_o | output | NOPS | Per operand: apply offset in this element |
| done_o | output | 1 | One-cycle pulse after the last element |

## Verification
The bench sweeps vector lengths from 0 through XLEN+4, plus the all-ones value, against every redirection pattern and several vector-flag patterns. This set separates the normal counted loop from the two scalar fall-backs (length zero and no redirection) and from the clamp above XLEN. Every other case repeats with start held high and all inputs toggled during the loop and during the done cycle. A loop that re-reads its inputs, or restarts on a busy start, therefore shows a wrong count, a wrong offset or a wrong step mask.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Number of element-valid cycles for one instruction.
  function automatic int unsigned elem_count(input int unsigned vl,
                                             input int unsigned xlen,
                                             input logic        any_redir);
    if (!any_redir || vl == 0) return 1;
    if (vl > xlen) return xlen;
    return vl;
  endfunction

  // Index of the final element.
  function automatic int unsigned last_index(input int unsigned vl,
                                             input int unsigned xlen,
                                             input logic        any_redir);
    return elem_count(vl, xlen, any_redir) - 1;
  endfunction

endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_hit_i,
  output logic accept_o,
  output logic run_o,
  output logic done_o
);

  seq_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last_hit_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !run_o));

  // R6
  last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && last_hit_i) |=> done_o);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_hit_i) |=> run_o);

endmodule

// File: rtl/vls_count.sv
module vls_count
  import vls_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int VL_W  = 8,
  parameter int OFF_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             run_i,
  input  logic [VL_W-1:0]  vlen_i,
  input  logic             any_redir_i,
  output logic [OFF_W-1:0] off_o,
  output logic             last_hit_o
);

  logic [OFF_W-1:0] off_q, last_q;
  logic [OFF_W-1:0] last_d;

  assign last_d = OFF_W'(last_index(32'(vlen_i), XLEN, any_redir_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      last_q <= '0;
    end else if (accept_i) begin
      off_q  <= '0;
      last_q <= last_d;
    end else if (run_i && !last_hit_o) begin
      off_q  <= off_q + 1'b1;
    end
  end

  assign off_o      = off_q;
  assign last_hit_o = (off_q == last_q);

  // R2
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !last_hit_o) |=> (off_o == OFF_W'($past(off_o) + 1'b1)));

  // R9
  off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !accept_i) |=> $stable(off_o));

endmodule

// File: rtl/vls_opmask.sv
module vls_opmask #(
  parameter int NOPS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic [NOPS-1:0] redir_i,
  input  logic [NOPS-1:0] vec_i,
  output logic            any_redir_o,
  output logic [NOPS-1:0] mask_o
);

  logic [NOPS-1:0] mask_q;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[k] <= 1'b0;
      else if (accept_i) mask_q[k] <= redir_i[k] & vec_i[k];
    end
  end

  assign any_redir_o = |redir_i;
  assign mask_o      = mask_q;

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(mask_o));

endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq #(
  parameter int XLEN  = 16,
  parameter int VL_W  = 8,
  parameter int NOPS  = 3,
  localparam int OFF_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vlen_i,
  input  logic [NOPS-1:0]  op_redir_i,
  input  logic [NOPS-1:0]  op_vec_i,
  output logic [OFF_W-1:0] elem_off_o,
  output logic             elem_vld_o,
  output logic [NOPS-1:0]  op_step_o,
  output logic             done_o
);

  logic             accept_w;
  logic             run_w;
  logic             last_hit_w;
  logic             any_redir_w;
  logic [OFF_W-1:0] off_w;
  logic [NOPS-1:0]  mask_w;

  vls_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .last_hit_i (last_hit_w),
    .accept_o   (accept_w),
    .run_o      (run_w),
    .done_o     (done_o)
  );

  vls_opmask #(.NOPS(NOPS)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .redir_i     (op_redir_i),
    .vec_i       (op_vec_i),
    .any_redir_o (any_redir_w),
    .mask_o      (mask_w)
  );

  vls_count #(.XLEN(XLEN), .VL_W(VL_W), .OFF_W(OFF_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .run_i       (run_w),
    .vlen_i      (vlen_i),
    .any_redir_i (any_redir_w),
    .off_o       (off_w),
    .last_hit_o  (last_hit_w)
  );

  assign elem_vld_o = run_w;
  assign elem_off_o = run_w ? off_w : '0;
  assign op_step_o  = run_w ? mask_w : '0;

  // R2
  first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(elem_vld_o) |-> (elem_off_o == '0));

  // R3
  scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && (vlen_i == '0 || op_redir_i == '0)) |=> (elem_vld_o && last_hit_w));

  // R6
  vld_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(elem_vld_o && done_o));

  // R8
  step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_vld_o |-> (op_step_o == '0));

endmodule

// File: tb/vec_loop_seq_test.sv
module vec_loop_seq_test;

  localparam int XLEN  = 16;
  localparam int VL_W  = 8;
  localparam int NOPS  = 3;
  localparam int OFF_W = $clog2(XLEN);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [VL_W-1:0]  vlen_i = '0;
  logic [NOPS-1:0]  op_redir_i = '0;
  logic [NOPS-1:0]  op_vec_i = '0;
  logic [OFF_W-1:0] elem_off_o;
  logic             elem_vld_o;
  logic [NOPS-1:0]  op_step_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vec_loop_seq #(.XLEN(XLEN), .VL_W(VL_W), .NOPS(NOPS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .op_redir_i(op_redir_i), .op_vec_i(op_vec_i), .elem_off_o(elem_off_o),
    .elem_vld_o(elem_vld_o), .op_step_o(op_step_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_count(input int vl, input int redir);
    if (vl == 0 || redir == 0) return 1;
    if (vl > XLEN) return XLEN;
    return vl;
  endfunction

  function automatic string req_of(input int vl, input int redir);
    if (redir == 0) return "R4";
    if (vl == 0) return "R3";
    if (vl > XLEN) return "R5";
    return "R2";
  endfunction

  task automatic run_case(input int vl, input int redir, input int vec, input bit disturb);
    int n;
    int m;
    string rq;
    n  = exp_count(vl, redir);
    m  = redir & vec;
    rq = req_of(vl, redir);
    @(negedge clk);
    start_i    = 1'b1;
    vlen_i     = VL_W'(vl);
    op_redir_i = NOPS'(redir);
    op_vec_i   = NOPS'(vec);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (disturb) begin
        start_i    = 1'b1;
        vlen_i     = VL_W'(vl + 3 + i);
        op_redir_i = ~NOPS'(redir);
        op_vec_i   = ~NOPS'(vec);
      end else begin
        start_i = 1'b0;
      end
      check(elem_vld_o == 1'b1, rq, "elem_vld", int'(elem_vld_o), 1);
      check(int'(elem_off_o) == i, rq, "elem_off", int'(elem_off_o), i);
      check(done_o == 1'b0, "R6", "done during element", int'(done_o), 0);
      // R8 step mask during a valid cycle; R9 when disturbed
      check(int'(op_step_o) == m, disturb ? "R9" : "R8", "op_step", int'(op_step_o), m);
    end
    @(negedge clk);
    // R6 done in the cycle after the last element; R7/R9 no extra element
    check(done_o == 1'b1, "R6", "done pulse", int'(done_o), 1);
    check(elem_vld_o == 1'b0, disturb ? "R7" : "R6", "vld after last", int'(elem_vld_o), 0);
    check(op_step_o == '0, "R8", "op_step idle", int'(op_step_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    // R7 start held in the done cycle does not relaunch
    check(elem_vld_o == 1'b0, "R7", "vld after done", int'(elem_vld_o), 0);
    check(done_o == 1'b0, "R6", "done width", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx;
    int vecs[4];
    vecs[0] = 0; vecs[1] = 7; vecs[2] = 5; vecs[3] = 2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(elem_vld_o == 1'b0, "R1", "vld in reset", int'(elem_vld_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(elem_off_o == '0, "R1", "off in reset", int'(elem_off_o), 0);
    check(op_step_o == '0, "R1", "step in reset", int'(op_step_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(elem_vld_o == 1'b0, "R1", "vld after reset", int'(elem_vld_o), 0);
    idx = 0;
    for (int vl = 0; vl <= XLEN + 4; vl++) begin
      for (int r = 0; r < 8; r++) begin
        for (int v = 0; v < 4; v++) begin
          run_case(vl, r, vecs[v], idx[0]);
          idx++;
        end
      end
    end
    for (int r = 0; r < 8; r++) begin
      run_case(255, r, 7, 1'b0);
      run_case(255, r, 3, 1'b1);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule